// File: doc/BRIEF.md
# Serial Port Pin Role Controller

This block sets what each of four serial-port pins does and which way it points: one clock pin (SCK) and three control pins (SC0, SC1, SC2). It reads a synchronous/asynchronous mode select, the enables of transmitters 1 and 2, a normal/network mode select, and the frame-start and slot-start strobes of the serial engine. It also holds a small control word that carries one direction bit per pin and two output flag values. From these it drives an output enable and an output value for each pin. It hands the incoming pin levels to the engine's clock, frame-sync and flag inputs.

In synchronous mode, SCK is the shared clock and SC2 the shared frame sync. SC1 and SC0 are general-purpose flags 1 and 0, unless the matching transmitter takes the pin for its data. In asynchronous mode, SCK carries the transmit clock, SC2 the transmit frame sync, SC1 the receive frame sync and SC0 the receive clock.

Flag values do not reach the pins straight from the control word. They pass through a separate pin register. That register loads only on a frame start in normal mode, or only on a slot start in network mode. A flag write therefore never disturbs a frame in progress. Flag pins used as inputs pass through a synchronizer before they are reported.

Top module: `sport_pin_role`

## Requirements
- R1: A cycle with `ctl_we` high loads `ctl_wdata` into the control word. Bit 5 is the SCK direction, bit 4 the SC2 direction, bit 3 the SC1 direction and bit 2 the SC0 direction, where 1 means output and 0 means input. Bit 1 is the flag 1 value and bit 0 the flag 0 value.
- R2: `soft_rst` clears the control word and both flag pin registers at the next edge, and it takes priority over a write in the same cycle.
- R3: `sck_oe` equals direction bit 5 and `sc_oe[2]` equals direction bit 4 in both modes. `sck_o` carries `tx_clk_out` and `sc_o[2]` carries `tx_fs_out`.
- R4: A high `tx1_en` forces `sc_oe[0]` to 1 whatever bit 2 holds; otherwise `sc_oe[0]` follows bit 2. `sc_o[0]` carries `tx1_dat` in synchronous mode with transmitter 1 on, the flag 0 pin register in synchronous mode with it off, and `rx_clk_out` in asynchronous mode.
- R5: In synchronous mode with `tx2_en` high, `sc_oe[1]` is 1 and `sc_o[1]` carries `tx2_dat`. In every other case `sc_oe[1]` follows bit 3. `sc_o[1]` carries the flag 1 pin register in synchronous mode and `rx_fs_out` in asynchronous mode.
- R6: With `net_mode` low, the flag pin registers load control bits 1:0 at an edge where `frame_start` is high; `slot_start` has no effect.
- R7: With `net_mode` high, the flag pin registers load control bits 1:0 at an edge where `slot_start` is high; `frame_start` has no effect.
- R8: Writing the control word without a qualifying strobe leaves the flag pin values unchanged.
- R9: `tx_clk_in` is `sck_i` and `tx_fs_in` is `sc_i[2]`. In synchronous mode `rx_clk_in` is `sck_i` and `rx_fs_in` is `sc_i[2]`. In asynchronous mode `rx_clk_in` is `sc_i[0]` and `rx_fs_in` is `sc_i[1]`.
- R10: `flag_in[k]` reports `sc_i[k]` after `IN_SYNC_STAGES` edges. It does so only while pin SCk is a flag (synchronous mode, its transmitter off) and configured as an input; otherwise it is 0.
- R11: After `rst_n` low, all output enables, the control word and the flag pin registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset request |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| syn_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| net_mode | input | 1 | 1 = network, 0 = normal |
| tx1_en | input | 1 | Transmitter 1 enable |
| tx2_en | input | 1 | Transmitter 2 enable |
| frame_start | input | 1 | Frame start strobe |
| slot_start | input | 1 | Time slot start strobe |
| tx_clk_out | input | 1 | Engine transmit clock to drive |
| tx_fs_out | input | 1 | Engine transmit frame sync to drive |
| rx_clk_out | input | 1 | Engine receive clock to drive |
| rx_fs_out | input | 1 | Engine receive frame sync to drive |
| tx1_dat | input | 1 | Transmitter 1 serial data |
| tx2_dat | input | 1 | Transmitter 2 serial data |
| sck_i | input | 1 | SCK pin level |
| sck_o | output | 1 | SCK drive value |
| sck_oe | output | 1 | SCK output enable |
| sc_i | input | 3 | SC2..SC0 pin levels |
| sc_o | output | 3 | SC2..SC0 drive values |
| sc_oe | output | 3 | SC2..SC0 output enables |
| tx_clk_in | output | 1 | Transmit clock seen at pins |
| rx_clk_in | output | 1 | Receive clock seen at pins |
| tx_fs_in | output | 1 | Transmit frame sync seen at pins |
| rx_fs_in | output | 1 | Receive frame sync seen at pins |
| flag_in | output | 2 | Synchronized input flags 1..0 |

## Verification
Every combination of mode, both transmitter enables and the four direction bits is applied. For each one the enables are checked, the drive values are checked with the engine signals in two opposite patterns, and all sixteen pin-level patterns are checked on the routed inputs. This separates the forced-output cases from the direction-bit cases, and the synchronous routing from the asynchronous routing. The flag path gets strobe sequences in both normal and network modes; writes without a strobe and the wrong strobe must leave the pins untouched, and only the matching strobe may load. The input flags are tried across role, direction and mode changes to show that they gate to zero.

// File: rtl/sport_pin_pkg.sv
package sport_pin_pkg;
   localparam int CTRL_W   = 6;
   localparam int SCKD_POS = 5;
   localparam int SC2D_POS = 4;
   localparam int SC1D_POS = 3;
   localparam int SC0D_POS = 2;
   localparam int OF1_POS  = 1;
   localparam int OF0_POS  = 0;
   localparam int FLAG_CNT = 2;
   localparam int DIR_CNT  = 4;

   typedef enum logic [1:0] {
      ROLE_FLAG   = 2'd0,
      ROLE_TXDATA = 2'd1,
      ROLE_RXCLK  = 2'd2,
      ROLE_RXFS   = 2'd3
   } sc_role_e;
endpackage

// File: rtl/sport_pin_sync.sv
module sport_pin_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] one_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) one_q <= '0;
            else        one_q <= d;
         end
         assign q = one_q;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            end else begin
               chain_q[0] <= d;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sport_flag_hold.sv
module sport_flag_hold #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         net_mode,
   input  logic         frame_start,
   input  logic         slot_start,
   input  logic [N-1:0] of_bits,
   output logic [N-1:0] flag_q
);
   logic ld;
   assign ld = net_mode ? slot_start : frame_start;

   generate
      for (genvar k = 0; k < N; k++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  flag_q[k] <= 1'b0;
            else if (clr) flag_q[k] <= 1'b0;
            else if (ld)  flag_q[k] <= of_bits[k];
         end
      end
   endgenerate

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(net_mode ? slot_start : frame_start)) |=> $stable(flag_q));
   // R7
   net_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && net_mode && slot_start) |=> (flag_q == $past(of_bits)));
   // R6
   norm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !net_mode && frame_start) |=> (flag_q == $past(of_bits)));
   // R2
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flag_q == '0));
endmodule

// File: rtl/sport_pin_dir.sv
module sport_pin_dir
   import sport_pin_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               syn_mode,
   input  logic               tx1_en,
   input  logic               tx2_en,
   input  logic [DIR_CNT-1:0] dir_bits,
   output logic [DIR_CNT-1:0] pin_oe,
   output sc_role_e           role_sc0,
   output sc_role_e           role_sc1
);
   always_comb begin
      if (!syn_mode)   role_sc0 = ROLE_RXCLK;
      else if (tx1_en) role_sc0 = ROLE_TXDATA;
      else             role_sc0 = ROLE_FLAG;

      if (!syn_mode)   role_sc1 = ROLE_RXFS;
      else if (tx2_en) role_sc1 = ROLE_TXDATA;
      else             role_sc1 = ROLE_FLAG;
   end

   assign pin_oe[3] = dir_bits[3];
   assign pin_oe[2] = dir_bits[2];
   assign pin_oe[1] = (role_sc1 == ROLE_TXDATA) | dir_bits[1];
   assign pin_oe[0] = tx1_en | dir_bits[0];

   // R4
   tx1_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx1_en |-> pin_oe[0]);
   // R5
   tx2_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_mode && tx2_en) |-> pin_oe[1]);
endmodule

// File: rtl/sport_pin_role.sv
module sport_pin_role
   import sport_pin_pkg::*;
#(
   parameter int IN_SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       ctl_we,
   input  logic [5:0] ctl_wdata,
   input  logic       syn_mode,
   input  logic       net_mode,
   input  logic       tx1_en,
   input  logic       tx2_en,
   input  logic       frame_start,
   input  logic       slot_start,
   input  logic       tx_clk_out,
   input  logic       tx_fs_out,
   input  logic       rx_clk_out,
   input  logic       rx_fs_out,
   input  logic       tx1_dat,
   input  logic       tx2_dat,
   input  logic       sck_i,
   output logic       sck_o,
   output logic       sck_oe,
   input  logic [2:0] sc_i,
   output logic [2:0] sc_o,
   output logic [2:0] sc_oe,
   output logic       tx_clk_in,
   output logic       rx_clk_in,
   output logic       tx_fs_in,
   output logic       rx_fs_in,
   output logic [1:0] flag_in
);
   generate
      if (IN_SYNC_STAGES < 1 || IN_SYNC_STAGES > 4) begin : g_bad_sync
         $error("IN_SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic [CTRL_W-1:0]   ctrl_q;
   logic [DIR_CNT-1:0]  dir_bits;
   logic [DIR_CNT-1:0]  pin_oe;
   logic [FLAG_CNT-1:0] of_bits;
   logic [FLAG_CNT-1:0] flag_q;
   logic [FLAG_CNT-1:0] sync_q;
   sc_role_e            role_sc0;
   sc_role_e            role_sc1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (soft_rst) ctrl_q <= '0;
      else if (ctl_we)   ctrl_q <= ctl_wdata;
   end

   assign dir_bits = {ctrl_q[SCKD_POS], ctrl_q[SC2D_POS], ctrl_q[SC1D_POS], ctrl_q[SC0D_POS]};
   assign of_bits  = {ctrl_q[OF1_POS], ctrl_q[OF0_POS]};

   sport_pin_dir i_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .syn_mode (syn_mode),
      .tx1_en   (tx1_en),
      .tx2_en   (tx2_en),
      .dir_bits (dir_bits),
      .pin_oe   (pin_oe),
      .role_sc0 (role_sc0),
      .role_sc1 (role_sc1)
   );

   sport_flag_hold #(.N(FLAG_CNT)) i_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (soft_rst),
      .net_mode    (net_mode),
      .frame_start (frame_start),
      .slot_start  (slot_start),
      .of_bits     (of_bits),
      .flag_q      (flag_q)
   );

   sport_pin_sync #(.STAGES(IN_SYNC_STAGES), .W(FLAG_CNT)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sc_i[1:0]),
      .q     (sync_q)
   );

   assign sck_oe = pin_oe[3];
   assign sc_oe  = pin_oe[2:0];
   assign sck_o  = tx_clk_out;
   assign sc_o[2] = tx_fs_out;

   always_comb begin
      unique case (role_sc0)
         ROLE_FLAG:   sc_o[0] = flag_q[0];
         ROLE_TXDATA: sc_o[0] = tx1_dat;
         ROLE_RXCLK:  sc_o[0] = rx_clk_out;
         default:     sc_o[0] = 1'b0;
      endcase
      unique case (role_sc1)
         ROLE_FLAG:   sc_o[1] = flag_q[1];
         ROLE_TXDATA: sc_o[1] = tx2_dat;
         ROLE_RXFS:   sc_o[1] = rx_fs_out;
         default:     sc_o[1] = 1'b0;
      endcase
   end

   assign tx_clk_in = sck_i;
   assign tx_fs_in  = sc_i[2];
   assign rx_clk_in = (role_sc0 == ROLE_RXCLK) ? sc_i[0] : sck_i;
   assign rx_fs_in  = (role_sc1 == ROLE_RXFS)  ? sc_i[1] : sc_i[2];

   assign flag_in[0] = (role_sc0 == ROLE_FLAG) && !pin_oe[0] && sync_q[0];
   assign flag_in[1] = (role_sc1 == ROLE_FLAG) && !pin_oe[1] && sync_q[1];

   // R2
   ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == '0));
   // R1
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !soft_rst) |=> (ctrl_q == $past(ctl_wdata)));
   // R10
   flag_in_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_in != '0) |-> (syn_mode && ((flag_in & sc_oe[1:0]) == '0)));
   // R11
   reset_oe_chk: assert property (@(posedge clk)
      !rst_n |-> (!sck_oe && sc_oe == '0));
endmodule

// File: tb/test_sport_pin_role.sv
`timescale 1ns/1ps
module test_sport_pin_role;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 0, ctl_we = 0;
   logic [5:0] ctl_wdata = '0;
   logic syn_mode = 0, net_mode = 0, tx1_en = 0, tx2_en = 0;
   logic frame_start = 0, slot_start = 0;
   logic tx_clk_out = 0, tx_fs_out = 0, rx_clk_out = 0, rx_fs_out = 0;
   logic tx1_dat = 0, tx2_dat = 0;
   logic sck_i = 0;
   logic [2:0] sc_i = '0;
   logic sck_o, sck_oe;
   logic [2:0] sc_o, sc_oe;
   logic tx_clk_in, rx_clk_in, tx_fs_in, rx_fs_in;
   logic [1:0] flag_in;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sport_pin_role #(.IN_SYNC_STAGES(SYNC)) i_sport_pin_role (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .syn_mode(syn_mode), .net_mode(net_mode),
      .tx1_en(tx1_en), .tx2_en(tx2_en), .frame_start(frame_start),
      .slot_start(slot_start), .tx_clk_out(tx_clk_out), .tx_fs_out(tx_fs_out),
      .rx_clk_out(rx_clk_out), .rx_fs_out(rx_fs_out), .tx1_dat(tx1_dat),
      .tx2_dat(tx2_dat), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .sc_i(sc_i), .sc_o(sc_o), .sc_oe(sc_oe), .tx_clk_in(tx_clk_in),
      .rx_clk_in(rx_clk_in), .tx_fs_in(tx_fs_in), .rx_fs_in(rx_fs_in),
      .flag_in(flag_in)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [5:0] v);
      @(negedge clk); ctl_we = 1; ctl_wdata = v;
      @(negedge clk); ctl_we = 0;
   endtask

   task automatic pulse_frame();
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
   endtask

   task automatic pulse_slot();
      @(negedge clk); slot_start = 1;
      @(negedge clk); slot_start = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 oe", {4'b0, sck_oe, sc_oe}, 8'h00);
      chk("R11 flags", {6'b0, sc_o[1:0]}, 8'h00);
      rst_n = 1;
      @(negedge clk);

      // R1 R3 R4 R5 R9: sweep of mode, transmitter enables and direction bits
      for (int s = 0; s < 2; s++) begin
         for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 16; d++) begin
               logic [3:0] dd;
               logic e1, e2, ys;
               dd = d[3:0]; ys = s[0]; e1 = t[0]; e2 = t[1];
               @(negedge clk); syn_mode = ys; tx1_en = e1; tx2_en = e2;
               wr_ctrl({dd, 2'b00});
               chk("R1 R3 R4 R5 oe", {4'b0, sck_oe, sc_oe},
                   {4'b0, dd[3], dd[2], (ys & e2) | dd[1], e1 | dd[0]});
               for (int p = 0; p < 2; p++) begin
                  logic pv;
                  logic [3:0] eo;
                  pv = p[0];
                  tx_clk_out = pv; tx_fs_out = ~pv; rx_clk_out = pv;
                  rx_fs_out = ~pv; tx1_dat = ~pv; tx2_dat = pv;
                  #0.5;
                  eo[3] = pv;
                  eo[2] = ~pv;
                  eo[1] = ys ? (e2 ? pv : 1'b0) : ~pv;
                  eo[0] = ys ? (e1 ? ~pv : 1'b0) : pv;
                  chk("R3 R4 R5 out", {4'b0, sck_o, sc_o}, {4'b0, eo});
               end
               for (int v = 0; v < 16; v++) begin
                  logic [3:0] vv;
                  vv = v[3:0];
                  sck_i = vv[3]; sc_i = vv[2:0];
                  #0.1;
                  chk("R9 route", {4'b0, tx_clk_in, rx_clk_in, tx_fs_in, rx_fs_in},
                      {4'b0, vv[3], ys ? vv[3] : vv[0], vv[2], ys ? vv[2] : vv[1]});
               end
            end
         end
      end

      // R10 flag inputs
      @(negedge clk); syn_mode = 1; tx1_en = 0; tx2_en = 0; sc_i = 3'b011;
      wr_ctrl(6'b000000);
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      chk("R10 both inputs", {6'b0, flag_in}, 8'h03);
      wr_ctrl(6'b001000);
      chk("R10 sc1 output", {6'b0, flag_in}, 8'h01);
      @(negedge clk); tx1_en = 1; #0.1;
      chk("R10 tx1 takes sc0", {6'b0, flag_in}, 8'h00);
      @(negedge clk); tx1_en = 0; syn_mode = 0; wr_ctrl(6'b000000); #0.1;
      chk("R10 async", {6'b0, flag_in}, 8'h00);
      @(negedge clk); syn_mode = 1; sc_i = 3'b010;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      chk("R10 new level", {6'b0, flag_in}, 8'h02);

      // R6 R8 normal mode flag updates
      @(negedge clk); net_mode = 0; tx1_en = 0; tx2_en = 0; syn_mode = 1;
      wr_ctrl(6'b001111);
      chk("R8 write no strobe", {6'b0, sc_o[1:0]}, 8'h00);
      pulse_slot();
      chk("R6 slot ignored", {6'b0, sc_o[1:0]}, 8'h00);
      pulse_frame();
      chk("R6 frame loads", {6'b0, sc_o[1:0]}, 8'h03);

      // R7 network mode
      @(negedge clk); net_mode = 1;
      wr_ctrl(6'b001101);
      chk("R8 write no strobe net", {6'b0, sc_o[1:0]}, 8'h03);
      pulse_frame();
      chk("R7 frame ignored", {6'b0, sc_o[1:0]}, 8'h03);
      pulse_slot();
      chk("R7 slot loads", {6'b0, sc_o[1:0]}, 8'h01);

      // R2 soft reset beats write
      @(negedge clk); soft_rst = 1; ctl_we = 1; ctl_wdata = 6'b111111;
      @(negedge clk); soft_rst = 0; ctl_we = 0;
      chk("R2 oe cleared", {4'b0, sck_oe, sc_oe}, 8'h00);
      chk("R2 flags cleared", {6'b0, sc_o[1:0]}, 8'h00);
      pulse_slot();
      chk("R2 of bits cleared", {6'b0, sc_o[1:0]}, 8'h00);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule